// File: doc/BRIEF.md
# EPP Cycle Gate with Sticky Timeout

This block is the host-facing front end of an enhanced parallel port. It holds the port's control byte and output data byte. It serves a status byte assembled from an external source. It turns host accesses to the EPP address and EPP data offsets into byte-wide request/acknowledge/error cycles on an external cable engine. An external cycle starts only when the control byte holds the exact pattern that mode needs. Any other access returns at once: a write is dropped, and a read returns all ones.

The host presents an access by holding `host_valid` with its offset, direction, size and write data. The block answers with a one-cycle `host_ready` pulse, and `host_rdata` is valid during that cycle. The host must drop `host_valid`, or present a new access, in the cycle after the pulse. Wide EPP data accesses are cut into bytes and sent least-significant byte first. Read bytes are put back together in the same order. An error response from the cable engine sets a sticky timeout bit. That bit appears as bit 0 of the status byte and is cleared by software.

Top module: `epp_port`

## Requirements
- R1: After reset the control byte reads 0xCC, the data byte reads 0xFF, and the timeout bit (status bit 0) is 0.
- R2: A control write (offset 2) stores the written byte with bits 7 and 6 forced to 1 and pulses `ctrl_update`. A write whose forced value equals the stored byte changes nothing and gives no pulse.
- R3: A control write that changes bit 5 (direction, 1 = read) also pulses `dir_change`, in the same cycle as `ctrl_update`. Other control changes do not pulse it.
- R4: A data write (offset 0) with a new value updates `pdata_out` and pulses `pdata_update`. A write of the held value gives no pulse. A data read returns the held byte.
- R5: An EPP write (offset 3 or 4) starts external cycles only when control AND 0x2F equals 0x04. Otherwise no external cycle occurs.
- R6: An EPP read starts external cycles only when control AND 0x2F equals 0x24. Otherwise no external cycle occurs, and the read returns 0xFF, 0xFFFF or 0xFFFFFFFF according to its width.
- R7: An offset-3 access is always one byte with `cyc_addr`=1, whatever its size code. Offset-4 accesses use `cyc_addr`=0.
- R8: At offset 4, the size code 0/1/2/3 gives 1/2/4/4 bytes. Byte n goes to or from `host_wdata`/`host_rdata` bits 8n+7:8n, in rising n. Read bits above the width are 0.
- R9: `cyc_req` stays high, with `cyc_addr`, `cyc_read` and `cyc_wbyte` held, until `cyc_ack` or `cyc_err` is sampled. It is low for at least one cycle after each response.
- R10: A `cyc_err` response sets the timeout bit and ends the access. No later byte is transferred, and read bytes not received return 0xFF.
- R11: A status read (offset 1) returns `ext_status` bits 7:1 with the timeout bit in bit 0. A status write with bit 0 set clears the timeout bit; with bit 0 clear it leaves it.
- R12: `host_ready` is a single-cycle pulse. Offsets 5 to 7 read 0xFF, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Access presented |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| host_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| host_ready | output | 1 | Access complete pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| ext_status | input | 7 | External status bits 7:1 |
| ctrl_out | output | 8 | Stored control byte |
| ctrl_update | output | 1 | Control byte changed |
| dir_change | output | 1 | Direction bit changed |
| pdata_out | output | 8 | Stored data byte |
| pdata_update | output | 1 | Data byte changed |
| cyc_req | output | 1 | External byte cycle request |
| cyc_addr | output | 1 | 1 = address cycle, 0 = data cycle |
| cyc_read | output | 1 | 1 = read cycle |
| cyc_wbyte | output | 8 | Byte to send on write cycles |
| cyc_ack | input | 1 | Cycle completed |
| cyc_err | input | 1 | Cycle failed |
| cyc_rbyte | input | 8 | Byte received, sampled with cyc_ack |

## Verification
The mode gate is exercised with control values that match the write pattern, the read pattern, and near misses such as a set strobe bit or the wrong direction. This tells an exact-match gate apart from a check of the direction bit alone. Transfers of one, two and four bytes use distinct byte values, with a cable response delay of zero and of several cycles. These runs expose byte-order swaps, lost or repeated bytes, and requests that drop early. An error injected mid-access shows whether later bytes are suppressed, and whether the timeout bit survives a zero write and clears on a one write.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int HOST_BYTES = 4;
  localparam int HOST_W     = HOST_BYTES * 8;
  localparam int IDX_W      = $clog2(HOST_BYTES);

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_EADR = 3'd3;
  localparam logic [2:0] OFF_EDAT = 3'd4;

  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;
  localparam logic [7:0] CTRL_RST  = 8'hCC;
  localparam logic [7:0] CTRL_ONES = 8'hC0;
  localparam int         DIR_BIT   = 5;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_DONE} seq_state_t;

  // index of the final byte of an access
  function automatic logic [IDX_W-1:0] last_byte(input logic [2:0] off, input logic [1:0] sz);
    if (off == OFF_EADR || sz == 2'd0) return '0;
    else if (sz == 2'd1)               return IDX_W'(1);
    else                               return IDX_W'(HOST_BYTES - 1);
  endfunction

  // all-ones in bytes 0..last, zero above
  function automatic logic [HOST_W-1:0] byte_mask(input logic [IDX_W-1:0] last);
    logic [HOST_W-1:0] m;
    m = '0;
    for (int i = 0; i < HOST_BYTES; i++)
      if (i <= int'(last)) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/epp_regs.sv
module epp_regs
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       host_write,
  input  logic [2:0] host_addr,
  input  logic [7:0] wbyte,
  input  logic [7:1] ext_status,
  input  logic       err_hit,
  output logic [7:0] ctrl_q,
  output logic [7:0] data_q,
  output logic       tmo_q,
  output logic [7:0] rd_byte,
  output logic       ctrl_update,
  output logic       dir_change,
  output logic       pdata_update
);
  logic       wr;
  logic [7:0] ctrl_wv, ctrl_d, data_d;
  logic       tmo_d, cu_d, dc_d, pu_d;

  assign wr      = acc && host_write;
  assign ctrl_wv = wbyte | CTRL_ONES;

  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    tmo_d  = tmo_q;
    cu_d   = 1'b0;
    dc_d   = 1'b0;
    pu_d   = 1'b0;
    if (wr && host_addr == OFF_CTRL && ctrl_wv != ctrl_q) begin
      ctrl_d = ctrl_wv;
      cu_d   = 1'b1;
      dc_d   = ctrl_wv[DIR_BIT] != ctrl_q[DIR_BIT];
    end
    if (wr && host_addr == OFF_DATA && wbyte != data_q) begin
      data_d = wbyte;
      pu_d   = 1'b1;
    end
    if (err_hit)                                   tmo_d = 1'b1;
    else if (wr && host_addr == OFF_STAT && wbyte[0]) tmo_d = 1'b0;
  end

  always_comb begin
    case (host_addr)
      OFF_DATA: rd_byte = data_q;
      OFF_STAT: rd_byte = {ext_status, tmo_q};
      OFF_CTRL: rd_byte = ctrl_q;
      default:  rd_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= CTRL_RST;
      data_q       <= 8'hFF;
      tmo_q        <= 1'b0;
      ctrl_update  <= 1'b0;
      dir_change   <= 1'b0;
      pdata_update <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_d;
      data_q       <= data_d;
      tmo_q        <= tmo_d;
      ctrl_update  <= cu_d;
      dir_change   <= dc_d;
      pdata_update <= pu_d;
    end
  end

  assert_tmo_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> tmo_q);
  assert_ctrl_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:6] == 2'b11);
  assert_dir_with_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_change |-> ctrl_update);
endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [2:0]        host_addr,
  input  logic [1:0]        host_size,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic [7:0]        ctrl_q,
  input  logic [7:0]        reg_rdata,
  input  logic              cyc_ack,
  input  logic              cyc_err,
  input  logic [7:0]        cyc_rbyte,
  output logic              acc,
  output logic              host_ready,
  output logic [HOST_W-1:0] host_rdata,
  output logic              cyc_req,
  output logic              cyc_addr,
  output logic              cyc_read,
  output logic [7:0]        cyc_wbyte,
  output logic              err_hit
);
  seq_state_t        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d, acc_last;
  logic              isadr_q, isadr_d, isrd_q, isrd_d;
  logic [HOST_W-1:0] wbuf_q, wbuf_d, rbuf_q, rbuf_d;
  logic              is_epp, gate_ok;

  assign acc      = (st_q == S_IDLE) && host_valid;
  assign is_epp   = (host_addr == OFF_EADR) || (host_addr == OFF_EDAT);
  assign gate_ok  = host_write ? ((ctrl_q & GATE_MASK) == GATE_WR)
                               : ((ctrl_q & GATE_MASK) == GATE_RD);
  assign acc_last = last_byte(host_addr, host_size);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    last_d  = last_q;
    isadr_d = isadr_q;
    isrd_d  = isrd_q;
    wbuf_d  = wbuf_q;
    rbuf_d  = rbuf_q;
    err_hit = 1'b0;
    case (st_q)
      S_IDLE: if (host_valid) begin
        if (is_epp && gate_ok) begin
          st_d    = S_XFER;
          idx_d   = '0;
          last_d  = acc_last;
          isadr_d = host_addr == OFF_EADR;
          isrd_d  = !host_write;
          wbuf_d  = host_wdata;
          rbuf_d  = host_write ? '0 : byte_mask(acc_last);
        end else begin
          st_d   = S_DONE;
          rbuf_d = host_write ? '0 : (is_epp ? byte_mask(acc_last) : HOST_W'(reg_rdata));
        end
      end
      S_XFER: begin
        if (cyc_err) begin
          err_hit = 1'b1;
          st_d    = S_DONE;
        end else if (cyc_ack) begin
          if (isrd_q) rbuf_d[{idx_q, 3'b000} +: 8] = cyc_rbyte;
          if (idx_q == last_q) st_d = S_DONE;
          else begin
            idx_d = idx_q + 1'b1;
            st_d  = S_GAP;
          end
        end
      end
      S_GAP:   st_d = S_XFER;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      isadr_q <= 1'b0;
      isrd_q  <= 1'b0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      isadr_q <= isadr_d;
      isrd_q  <= isrd_d;
      wbuf_q  <= wbuf_d;
      rbuf_q  <= rbuf_d;
    end
  end

  assign host_ready = st_q == S_DONE;
  assign host_rdata = rbuf_q;
  assign cyc_req    = st_q == S_XFER;
  assign cyc_addr   = isadr_q;
  assign cyc_read   = isrd_q;
  assign cyc_wbyte  = wbuf_q[{idx_q, 3'b000} +: 8];

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && !cyc_ack && !cyc_err |=> cyc_req && $stable(cyc_wbyte) && $stable(cyc_addr) && $stable(cyc_read));
  assert_req_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && (cyc_ack || cyc_err) |=> !cyc_req);
  assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
endmodule

// File: rtl/epp_port.sv
module epp_port
  import epp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [2:0]        host_addr,
  input  logic [1:0]        host_size,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [HOST_W-1:0] host_rdata,
  input  logic [7:1]        ext_status,
  output logic [7:0]        ctrl_out,
  output logic              ctrl_update,
  output logic              dir_change,
  output logic [7:0]        pdata_out,
  output logic              pdata_update,
  output logic              cyc_req,
  output logic              cyc_addr,
  output logic              cyc_read,
  output logic [7:0]        cyc_wbyte,
  input  logic              cyc_ack,
  input  logic              cyc_err,
  input  logic [7:0]        cyc_rbyte
);
  logic       acc, err_hit, tmo_q;
  logic [7:0] ctrl_q, rd_byte;

  epp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .host_write(host_write),
    .host_addr(host_addr), .wbyte(host_wdata[7:0]), .ext_status(ext_status),
    .err_hit(err_hit), .ctrl_q(ctrl_q), .data_q(pdata_out), .tmo_q(tmo_q),
    .rd_byte(rd_byte), .ctrl_update(ctrl_update), .dir_change(dir_change),
    .pdata_update(pdata_update)
  );

  epp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .ctrl_q(ctrl_q), .reg_rdata(rd_byte), .cyc_ack(cyc_ack), .cyc_err(cyc_err),
    .cyc_rbyte(cyc_rbyte), .acc(acc), .host_ready(host_ready),
    .host_rdata(host_rdata), .cyc_req(cyc_req), .cyc_addr(cyc_addr),
    .cyc_read(cyc_read), .cyc_wbyte(cyc_wbyte), .err_hit(err_hit)
  );

  assign ctrl_out = ctrl_q;

  assert_wr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_req) && !cyc_read |-> (ctrl_q & GATE_MASK) == GATE_WR);
  assert_rd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_req) && cyc_read |-> (ctrl_q & GATE_MASK) == GATE_RD);
  assert_tmo_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(err_hit));
endmodule

// File: tb/epp_port_bench.sv
module epp_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic [7:1]  ext_status = 7'h52;
  logic [7:0]  ctrl_out, pdata_out, cyc_wbyte;
  logic        ctrl_update, dir_change, pdata_update;
  logic        cyc_req, cyc_addr, cyc_read;
  logic        cyc_ack = 1'b0, cyc_err = 1'b0;
  logic [7:0]  cyc_rbyte = '0;

  int checks = 0, errors = 0, lat = 0;
  logic [31:0] rd;
  logic        cu, dc, pu;
  // expected external cycle: {err, addr, read, byte}
  logic [10:0] expq[$];

  always #4 clk = ~clk;

  epp_port u_epp_port (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [2:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    host_valid = 1'b1; host_write = w; host_addr = a; host_size = sz; host_wdata = wd;
    forever begin
      @(negedge clk);
      if (host_ready) break;
    end
    rd = host_rdata; cu = ctrl_update; dc = dir_change; pu = pdata_update;
    host_valid = 1'b0;
    check(expq.size() == 0, "R5/R10 pending cycles", 32'(expq.size()), 0);
  endtask

  task automatic push(input bit e, input bit ad, input bit r, input logic [7:0] b);
    expq.push_back({e, ad, r, b});
  endtask

  // monitor / cable model: pops each expected cycle and answers it
  initial begin
    forever begin
      @(negedge clk);
      if (cyc_req) begin
        logic [10:0] it;
        if (expq.size() == 0) begin
          check(1'b0, "R5/R6 unexpected cycle", {cyc_addr, cyc_read, cyc_wbyte}, 0);
          it = '0;
        end else begin
          it = expq.pop_front();
          check(cyc_addr == it[9] && cyc_read == it[8], "R7 cycle kind",
                {cyc_addr, cyc_read}, it[9:8]);
          if (!it[8]) check(cyc_wbyte == it[7:0], "R8 write byte", cyc_wbyte, it[7:0]);
        end
        repeat (lat) begin
          @(negedge clk);
          check(cyc_req && (it[8] || cyc_wbyte == it[7:0]), "R9 request held", cyc_req, 1);
        end
        cyc_ack = !it[10]; cyc_err = it[10]; cyc_rbyte = it[7:0];
        @(negedge clk);
        cyc_ack = 1'b0; cyc_err = 1'b0;
        check(!cyc_req, "R9 gap after response", cyc_req, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    access(0, 3'd2, 0, 0); check(rd == 32'hCC, "R1 ctrl reset", rd, 32'hCC);
    access(0, 3'd0, 0, 0); check(rd == 32'hFF, "R1 data reset", rd, 32'hFF);
    access(0, 3'd1, 0, 0); check(rd == 32'hA4, "R1 R11 status reset", rd, 32'hA4);
    // gated off at reset control
    access(1, 3'd4, 2, 32'h12345678); // R5 no cycle expected
    access(0, 3'd4, 0, 0); check(rd == 32'hFF, "R6 ones 1B", rd, 32'hFF);
    access(0, 3'd4, 1, 0); check(rd == 32'hFFFF, "R6 ones 2B", rd, 32'hFFFF);
    // control programming
    access(1, 3'd2, 0, 32'h04); check(cu && !dc, "R2 ctrl change pulse", {cu, dc}, 2'b10);
    access(0, 3'd2, 0, 0); check(rd == 32'hC4, "R2 forced bits", rd, 32'hC4);
    access(1, 3'd2, 0, 32'hC4); check(!cu, "R2 identical ignored", cu, 0);
    // EPP writes
    push(0, 1, 0, 8'h5A); access(1, 3'd3, 2, 32'hAABBCC5A); // R7 single byte
    push(0, 0, 0, 8'h44); push(0, 0, 0, 8'h33); push(0, 0, 0, 8'h22); push(0, 0, 0, 8'h11);
    access(1, 3'd4, 2, 32'h11223344); // R8 little endian
    lat = 3;
    push(0, 0, 0, 8'hEF); push(0, 0, 0, 8'hBE);
    access(1, 3'd4, 1, 32'h0000BEEF); // R8 R9 with latency
    lat = 0;
    access(0, 3'd4, 0, 0); check(rd == 32'hFF, "R6 read blocked in write mode", rd, 32'hFF);
    // switch to read mode
    access(1, 3'd2, 0, 32'h24); check(cu && dc, "R3 dir change", {cu, dc}, 2'b11);
    push(0, 0, 1, 8'h01); push(0, 0, 1, 8'h02); push(0, 0, 1, 8'h03); push(0, 0, 1, 8'h04);
    access(0, 3'd4, 3, 0); check(rd == 32'h04030201, "R8 read assembly", rd, 32'h04030201);
    lat = 2;
    push(0, 1, 1, 8'h77);
    access(0, 3'd3, 2, 0); check(rd == 32'h77, "R7 addr read one byte", rd, 32'h77);
    push(0, 0, 1, 8'h9C); push(0, 0, 1, 8'hD3);
    access(0, 3'd4, 1, 0); check(rd == 32'hD39C, "R8 2B read", rd, 32'hD39C);
    lat = 0;
    access(1, 3'd4, 0, 32'h66); // R5 write dropped in read mode
    access(1, 3'd2, 0, 32'h25); check(cu && !dc, "R3 no dir change", {cu, dc}, 2'b10);
    access(0, 3'd4, 2, 0); check(rd == 32'hFFFFFFFF, "R6 strobe near miss", rd, 32'hFFFFFFFF);
    access(1, 3'd2, 0, 32'h24);
    // error mid-access
    push(0, 0, 1, 8'hA1); push(1, 0, 1, 8'h00);
    access(0, 3'd4, 2, 0); check(rd == 32'hFFFFFFA1, "R10 partial read", rd, 32'hFFFFFFA1);
    access(0, 3'd1, 0, 0); check(rd[0] == 1'b1, "R10 timeout set", rd, 32'hA5);
    ext_status = 7'h00;
    access(0, 3'd1, 0, 0); check(rd == 32'h01, "R11 status merge", rd, 32'h01);
    access(1, 3'd1, 0, 32'hFE);
    access(0, 3'd1, 0, 0); check(rd == 32'h01, "R11 zero write keeps", rd, 32'h01);
    access(1, 3'd1, 0, 32'h01);
    access(0, 3'd1, 0, 0); check(rd == 32'h00, "R11 one write clears", rd, 32'h00);
    // error on write: remaining bytes skipped
    access(1, 3'd2, 0, 32'h04);
    push(1, 0, 0, 8'h10);
    access(1, 3'd4, 2, 32'h40302010);
    access(0, 3'd1, 0, 0); check(rd == 32'h01, "R10 write error sticky", rd, 32'h01);
    // data register
    access(1, 3'd0, 0, 32'h3C); check(pu && pdata_out == 8'h3C, "R4 data update", {pu, pdata_out}, 9'h13C);
    access(1, 3'd0, 0, 32'h3C); check(!pu, "R4 equal no pulse", pu, 0);
    access(0, 3'd0, 0, 0); check(rd == 32'h3C, "R4 data read", rd, 32'h3C);
    // unused offsets
    access(0, 3'd6, 0, 0); check(rd == 32'hFF, "R12 unused read", rd, 32'hFF);
    access(1, 3'd7, 0, 32'h00);
    access(0, 3'd2, 0, 0); check(rd == 32'hC4 && ctrl_out == 8'hC4, "R12 unused write", rd, 32'hC4);
    @(negedge clk); check(!host_ready, "R12 ready pulse", host_ready, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule